// File: doc/BRIEF.md
# Threshold-Driven DMA Request Generator

This block produces the receive and transmit DMA request lines for a buffered serial port. It compares the fill level of the receive buffer (words held) and of the transmit buffer (slots free) against a threshold held for each direction. When there is enough data or room for one burst, it raises the matching request. A burst is threshold+1 words long. Once that many DMA strobes have been seen in a direction, its request is withdrawn. The request is raised again one cycle later at the earliest, if the level still allows.

The DMA engine is never blocked. An access that arrives outside a burst, or that the buffer cannot serve, is still carried out. A read from an empty receive buffer raises a one-cycle underflow pulse when underflow reporting is enabled. A write to a full transmit buffer raises a one-cycle overflow pulse when overflow reporting is enabled, and the write-accept output tells the storage to drop that word. The buffer storage and the serial shifter sit outside this block.

Top module: `sp_dma_req_gen`

## Requirements
- R1: After reset, both request outputs and both error pulses are low, and both thresholds are 0.
- R2: When the receive request is low and `rx_occupied` is at least the receive threshold plus one, `rx_dma_req` goes high on the next clock edge. It stays low while `rx_occupied` is at or below the threshold.
- R3: When the transmit request is low and `tx_free` is at least the transmit threshold plus one, `tx_dma_req` goes high on the next clock edge. It stays low while `tx_free` is at or below the threshold.
- R4: While a request is high, it stays high through the first threshold strobes (`rx_rd` or `tx_wr`). It drops on the clock edge that samples the strobe numbered threshold+1. The level inputs are not consulted during a burst.
- R5: A request that has just dropped stays low for at least one cycle. If the level condition still holds, the request rises again on the following edge.
- R6: Strobes that arrive while a request is low do not count toward the next burst. Each new burst needs a full threshold+1 strobes.
- R7: A `rx_rd` strobe while `rx_occupied` is 0 makes `rx_undf_pulse` high for exactly one cycle after that edge, but only if `rx_undf_en` is 1. Otherwise no pulse appears.
- R8: A `tx_wr` strobe while `tx_free` is 0 makes `tx_ovfl_pulse` high for one cycle after that edge, but only if `tx_ovfl_en` is 1. `tx_wr_accept` equals `tx_wr` when `tx_free` is nonzero and is 0 when `tx_free` is 0.
- R9: A threshold write stores the 7-bit value on the next edge, withdraws that direction's request and clears its burst count. Later bursts use the new length, up to a threshold of 127 with a level of 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_occupied | input | 8 | Words held in the receive buffer (0..128) |
| rx_rd | input | 1 | DMA read strobe, one per word |
| rx_thr_we | input | 1 | Receive threshold write |
| rx_thr_wdata | input | 7 | Receive threshold value |
| rx_undf_en | input | 1 | Receive underflow report enable |
| tx_free | input | 8 | Free slots in the transmit buffer (0..128) |
| tx_wr | input | 1 | DMA write strobe, one per word |
| tx_thr_we | input | 1 | Transmit threshold write |
| tx_thr_wdata | input | 7 | Transmit threshold value |
| tx_ovfl_en | input | 1 | Transmit overflow report enable |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_undf_pulse | output | 1 | One-cycle receive underflow event |
| tx_ovfl_pulse | output | 1 | One-cycle transmit overflow event |
| tx_wr_accept | output | 1 | Transmit write is to be stored |

## Verification
The hardest situation to reach is a threshold change in the middle of a burst. The new length must govern the next burst, and no count left over from the old burst may carry into it. The stimulus raises a request with threshold 0 and changes the threshold to 7 before any strobe arrives. It then shows that the request stays low until the level reaches 8, and that seven strobes keep the request high while the eighth drops it. A separate sequence sends strobes while the request is idle, then shows that a fresh burst still needs its full length.

// File: rtl/sp_dma_pkg.sv
package sp_dma_pkg;
  localparam int unsigned BUF_DEPTH = 128;
  localparam int unsigned LVL_W     = $clog2(BUF_DEPTH + 1);
  localparam int unsigned THR_W     = $clog2(BUF_DEPTH);
endpackage

// File: rtl/dma_burst_chan.sv
module dma_burst_chan #(
  parameter int unsigned THR_W = 7,
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic             strobe,
  input  logic [THR_W-1:0] thr,
  input  logic             thr_load,
  output logic             req
);
  logic             req_q, req_d;
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic             level_ok;

  // level >= thr + 1
  assign level_ok = level > LVL_W'(thr);

  always_comb begin
    req_d = req_q;
    cnt_d = cnt_q;
    if (thr_load) begin
      req_d = 1'b0;
      cnt_d = '0;
    end else if (req_q) begin
      if (strobe) begin
        if (cnt_q == thr) begin
          req_d = 1'b0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else if (level_ok) begin
      req_d = 1'b1;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      req_q <= req_d;
      cnt_q <= cnt_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/dma_access_err.sv
module dma_access_err #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [LVL_W-1:0] level,
  input  logic             en,
  output logic             pulse
);
  logic pulse_q, pulse_d;

  assign pulse_d = strobe && en && (level == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/sp_dma_req_gen.sv
module sp_dma_req_gen
  import sp_dma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] rx_occupied,
  input  logic             rx_rd,
  input  logic             rx_thr_we,
  input  logic [THR_W-1:0] rx_thr_wdata,
  input  logic             rx_undf_en,
  input  logic [LVL_W-1:0] tx_free,
  input  logic             tx_wr,
  input  logic             tx_thr_we,
  input  logic [THR_W-1:0] tx_thr_wdata,
  input  logic             tx_ovfl_en,
  output logic             rx_dma_req,
  output logic             tx_dma_req,
  output logic             rx_undf_pulse,
  output logic             tx_ovfl_pulse,
  output logic             tx_wr_accept
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [THR_W-1:0] rx_thr_q, tx_thr_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rx_thr_q <= '0;
      tx_thr_q <= '0;
    end else begin
      if (rx_thr_we) rx_thr_q <= rx_thr_wdata;
      if (tx_thr_we) tx_thr_q <= tx_thr_wdata;
    end
  end

  dma_burst_chan #(.THR_W(THR_W), .LVL_W(LVL_W)) u_rx_chan (
    .clk(clk), .rst_n(rst_int_n), .level(rx_occupied), .strobe(rx_rd),
    .thr(rx_thr_q), .thr_load(rx_thr_we), .req(rx_dma_req)
  );

  dma_burst_chan #(.THR_W(THR_W), .LVL_W(LVL_W)) u_tx_chan (
    .clk(clk), .rst_n(rst_int_n), .level(tx_free), .strobe(tx_wr),
    .thr(tx_thr_q), .thr_load(tx_thr_we), .req(tx_dma_req)
  );

  dma_access_err #(.LVL_W(LVL_W)) u_rx_err (
    .clk(clk), .rst_n(rst_int_n), .strobe(rx_rd), .level(rx_occupied),
    .en(rx_undf_en), .pulse(rx_undf_pulse)
  );

  dma_access_err #(.LVL_W(LVL_W)) u_tx_err (
    .clk(clk), .rst_n(rst_int_n), .strobe(tx_wr), .level(tx_free),
    .en(tx_ovfl_en), .pulse(tx_ovfl_pulse)
  );

  // a write into a full buffer is dropped
  assign tx_wr_accept = tx_wr && (tx_free != '0);
endmodule

// File: rtl/sp_dma_req_chk.sv
module sp_dma_req_chk
  import sp_dma_pkg::*;
(
  input logic             clk,
  input logic             rst_int_n,
  input logic [LVL_W-1:0] rx_occupied,
  input logic             rx_rd,
  input logic             rx_thr_we,
  input logic             rx_undf_en,
  input logic [THR_W-1:0] rx_thr_q,
  input logic [LVL_W-1:0] tx_free,
  input logic             tx_wr,
  input logic             tx_thr_we,
  input logic             tx_ovfl_en,
  input logic [THR_W-1:0] tx_thr_q,
  input logic             rx_dma_req,
  input logic             tx_dma_req,
  input logic             rx_undf_pulse,
  input logic             tx_ovfl_pulse,
  input logic             tx_wr_accept
);
  AST_RX_REQ_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rx_dma_req) |-> $past(rx_occupied) > LVL_W'($past(rx_thr_q))); // R2
  AST_TX_REQ_NEEDS_SPACE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(tx_dma_req) |-> $past(tx_free) > LVL_W'($past(tx_thr_q))); // R3
  AST_RX_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(rx_dma_req) |-> ($past(rx_rd) || $past(rx_thr_we))); // R4
  AST_TX_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(tx_dma_req) |-> ($past(tx_wr) || $past(tx_thr_we))); // R4
  AST_RX_UNDF_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_undf_pulse |-> $past(rx_rd && rx_undf_en && (rx_occupied == '0))); // R7
  AST_TX_OVFL_CAUSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_ovfl_pulse |-> $past(tx_wr && tx_ovfl_en && (tx_free == '0))); // R8
  AST_TX_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_wr && tx_free == '0) |-> !tx_wr_accept); // R8
endmodule

bind sp_dma_req_gen sp_dma_req_chk u_chk (
  .clk(clk), .rst_int_n(rst_int_n),
  .rx_occupied(rx_occupied), .rx_rd(rx_rd), .rx_thr_we(rx_thr_we),
  .rx_undf_en(rx_undf_en), .rx_thr_q(rx_thr_q),
  .tx_free(tx_free), .tx_wr(tx_wr), .tx_thr_we(tx_thr_we),
  .tx_ovfl_en(tx_ovfl_en), .tx_thr_q(tx_thr_q),
  .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
  .rx_undf_pulse(rx_undf_pulse), .tx_ovfl_pulse(tx_ovfl_pulse),
  .tx_wr_accept(tx_wr_accept)
);

// File: tb/tb_sp_dma_req_gen.sv
module tb_sp_dma_req_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_occupied, tx_free;
  logic       rx_rd, rx_thr_we, rx_undf_en, tx_wr, tx_thr_we, tx_ovfl_en;
  logic [6:0] rx_thr_wdata, tx_thr_wdata;
  logic       rx_dma_req, tx_dma_req, rx_undf_pulse, tx_ovfl_pulse, tx_wr_accept;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_dma_req_gen dut (
    .clk(clk), .rst_n(rst_n),
    .rx_occupied(rx_occupied), .rx_rd(rx_rd), .rx_thr_we(rx_thr_we),
    .rx_thr_wdata(rx_thr_wdata), .rx_undf_en(rx_undf_en),
    .tx_free(tx_free), .tx_wr(tx_wr), .tx_thr_we(tx_thr_we),
    .tx_thr_wdata(tx_thr_wdata), .tx_ovfl_en(tx_ovfl_en),
    .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
    .rx_undf_pulse(rx_undf_pulse), .tx_ovfl_pulse(tx_ovfl_pulse),
    .tx_wr_accept(tx_wr_accept)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rx_strobe();
    rx_rd = 1'b1; cyc(); rx_rd = 1'b0;
  endtask

  task automatic tx_strobe();
    tx_wr = 1'b1; cyc(); tx_wr = 1'b0;
  endtask

  task automatic set_rx_thr(input logic [6:0] v);
    rx_thr_wdata = v; rx_thr_we = 1'b1; cyc(); rx_thr_we = 1'b0;
  endtask

  task automatic set_tx_thr(input logic [6:0] v);
    tx_thr_wdata = v; tx_thr_we = 1'b1; cyc(); tx_thr_we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rx_dma_req", rx_dma_req, 1'b0);
    chk("R1 tx_dma_req", tx_dma_req, 1'b0);
    chk("R1 rx_undf_pulse", rx_undf_pulse, 1'b0);
    chk("R1 tx_ovfl_pulse", tx_ovfl_pulse, 1'b0);
    rx_occupied = 8'd1; cyc(); // threshold 0 after reset: one word is enough
    chk("R1 default threshold 0", rx_dma_req, 1'b1);
    rx_strobe();
    chk("R1 burst of one", rx_dma_req, 1'b0);
    rx_occupied = 8'd0; cyc();
  endtask

  task automatic t_rx_burst();
    set_rx_thr(7'd3);
    rx_occupied = 8'd3; cyc(); cyc();
    chk("R2 level at threshold", rx_dma_req, 1'b0);
    rx_occupied = 8'd4; cyc();
    chk("R2 level at threshold+1", rx_dma_req, 1'b1);
    rx_occupied = 8'd1; // level ignored within burst
    for (int i = 0; i < 3; i++) begin
      rx_strobe();
      chk("R4 held inside burst", rx_dma_req, 1'b1);
    end
    rx_occupied = 8'd4;
    rx_strobe();
    chk("R4 drop after threshold+1 words", rx_dma_req, 1'b0);
    cyc();
    chk("R5 reassert next cycle", rx_dma_req, 1'b1);
    rx_occupied = 8'd0; rx_undf_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      rx_strobe();
      chk("R7 no pulse when disabled", rx_undf_pulse, 1'b0);
    end
    chk("R4 second burst ends", rx_dma_req, 1'b0);
    cyc();
    chk("R5 no reassert at low level", rx_dma_req, 1'b0);
  endtask

  task automatic t_idle_strobes();
    rx_strobe(); rx_strobe(); // idle strobes must not count
    rx_occupied = 8'd4; cyc();
    chk("R6 request after idle strobes", rx_dma_req, 1'b1);
    for (int i = 0; i < 3; i++) begin
      rx_strobe();
      chk("R6 full burst needed", rx_dma_req, 1'b1);
    end
    rx_strobe();
    chk("R6 burst end", rx_dma_req, 1'b0);
    rx_occupied = 8'd0; cyc();
  endtask

  task automatic t_underflow();
    rx_undf_en = 1'b1; rx_occupied = 8'd0;
    rx_strobe();
    chk("R7 underflow pulse", rx_undf_pulse, 1'b1);
    cyc();
    chk("R7 pulse one cycle", rx_undf_pulse, 1'b0);
    rx_occupied = 8'd2;
    rx_strobe();
    chk("R7 no pulse with data", rx_undf_pulse, 1'b0);
    rx_occupied = 8'd0; rx_undf_en = 1'b0; cyc();
  endtask

  task automatic t_tx_burst();
    set_tx_thr(7'd1);
    tx_free = 8'd1; cyc(); cyc();
    chk("R3 free at threshold", tx_dma_req, 1'b0);
    tx_free = 8'd2; cyc();
    chk("R3 free at threshold+1", tx_dma_req, 1'b1);
    tx_strobe();
    chk("R4 tx held", tx_dma_req, 1'b1);
    tx_free = 8'd0;
    tx_strobe();
    chk("R4 tx drop", tx_dma_req, 1'b0);
    cyc();
    chk("R5 tx stays low when full", tx_dma_req, 1'b0);
  endtask

  task automatic t_overflow();
    tx_free = 8'd0; tx_ovfl_en = 1'b1; tx_wr = 1'b1;
    #1;
    chk("R8 full write not accepted", tx_wr_accept, 1'b0);
    cyc(); tx_wr = 1'b0;
    chk("R8 overflow pulse", tx_ovfl_pulse, 1'b1);
    cyc();
    chk("R8 pulse one cycle", tx_ovfl_pulse, 1'b0);
    tx_ovfl_en = 1'b0;
    tx_strobe();
    chk("R8 no pulse when disabled", tx_ovfl_pulse, 1'b0);
    tx_free = 8'd1; tx_wr = 1'b1;
    #1;
    chk("R8 write accepted with space", tx_wr_accept, 1'b1);
    cyc(); tx_wr = 1'b0;
    tx_free = 8'd0; cyc();
  endtask

  task automatic t_thr_change();
    set_rx_thr(7'd0);
    rx_occupied = 8'd5; cyc();
    chk("R9 request with threshold 0", rx_dma_req, 1'b1);
    set_rx_thr(7'd7);
    chk("R9 write withdraws request", rx_dma_req, 1'b0);
    cyc();
    chk("R9 new threshold blocks level 5", rx_dma_req, 1'b0);
    rx_occupied = 8'd8; cyc();
    chk("R9 request at level 8", rx_dma_req, 1'b1);
    for (int i = 0; i < 7; i++) rx_strobe();
    chk("R9 seven words keep request", rx_dma_req, 1'b1);
    rx_strobe();
    chk("R9 eighth word drops request", rx_dma_req, 1'b0);
    rx_occupied = 8'd0;
    set_rx_thr(7'd127);
    rx_occupied = 8'd127; cyc(); cyc();
    chk("R9 threshold 127 level 127", rx_dma_req, 1'b0);
    rx_occupied = 8'd128; cyc();
    chk("R9 threshold 127 level 128", rx_dma_req, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0;
    rx_occupied = '0; tx_free = '0;
    rx_rd = 0; rx_thr_we = 0; rx_thr_wdata = '0; rx_undf_en = 0;
    tx_wr = 0; tx_thr_we = 0; tx_thr_wdata = '0; tx_ovfl_en = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    repeat (4) cyc();
    t_reset();
    t_rx_burst();
    t_idle_strobes();
    t_underflow();
    t_tx_burst();
    t_overflow();
    t_thr_change();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule